// File: doc/BRIEF.md
# Test-and-Set Lock Bank

This block is a bus target that holds a bank of one-bit hardware locks. It gives software atomic synchronisation on an interconnect that cannot lock the bus. Each lock occupies one 32-bit word of the target's address segment, and its index is the word offset from the segment base. A read is destructive. It returns the current bit and sets the bit to 1 in the same step. A write clears the bit whatever data it carries. A spin-lock acquire is therefore a loop of reads that ends on the first 0, and a release is a single write.

Requests arrive on a valid/ready channel that carries the address, a read/write flag, write data and byte enables. The write data and byte enables are ignored. Each request gets exactly one response on a valid/ready channel that carries read data and an error flag. Addresses are checked against the segment, so the block can also act as the default target for unmapped space.

The controller has two named states. `ST_IDLE` raises `req_ready`. When a request is accepted, the controller performs the lock update, captures the response and takes the transition IDLE->RESP. `ST_RESP` raises `rsp_valid` and holds the response. When `rsp_ready` is high it takes the transition RESP->IDLE; otherwise it stays in RESP->RESP. A synchronous active-low reset returns the controller to `ST_IDLE` and frees every lock. The segment base must be a multiple of 4; any other base stops elaboration.

Top module: `lock_bank`

## Requirements
- R1: After reset every lock reads as free (0), `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read (`req_write`=0) of an in-segment, word-aligned address returns the addressed lock bit in `rsp_rdata` bit 0, with bits 31:1 zero, and leaves that lock at 1. Two reads of a free lock in a row return 0 and then 1.
- R3: A write (`req_write`=1) of an in-segment, word-aligned address clears the addressed lock to 0 for any write data. It responds with `rsp_rdata`=0 and `rsp_err`=0.
- R4: The lock index is (`req_addr` - BASE_ADDR)/4. A request changes only the lock it addresses, and no lock changes while no request is accepted.
- R5: An address below BASE_ADDR, or at or above BASE_ADDR + 4*NUM_LOCKS, gets `rsp_err`=1 and `rsp_rdata`=0, and it changes no lock.
- R6: An address inside the segment with `req_addr[1:0]` not equal to 0 gets `rsp_err`=1 and `rsp_rdata`=0, and it changes no lock.
- R7: Requests are served one at a time. The response becomes valid in the cycle after the request is accepted. `req_ready` stays 0 while a response is pending, and every request gets exactly one response, in order.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid and `rsp_rdata` and `rsp_err` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write (clear the lock), 0 = read (test-and-set) |
| req_wdata | input | 32 | Write data, ignored |
| req_be | input | 4 | Byte enables, ignored |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer can accept |
| rsp_rdata | output | 32 | Read data: the lock bit zero-extended, 0 for writes and errors |
| rsp_err | output | 1 | Segmentation or alignment error |

## Verification
The atomic update is tried with repeated reads of one lock, which shows that a read both reports the bit and sets it. It is also tried with writes that carry all-zero and all-one data, which shows that the data has no effect on the clear. Reads of neighbouring and extreme indices (0 and NUM_LOCKS-1) separate a correct index decode from aliasing. Addresses just below the base, at the first word past the end, and misaligned inside the segment are each followed by a read of the lock they would alias, which shows that an error leaves the bank untouched. A phase with response back-pressure tells a held response apart from one that is dropped or overwritten, and shows that no second request is taken while a response is pending.

// File: rtl/lock_bank_pkg.sv
package lock_bank_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic {
        CMD_READ  = 1'b0,
        CMD_WRITE = 1'b1
    } lb_cmd_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } lb_state_e;

    typedef struct packed {
        logic              err;
        logic [WORD_W-1:0] data;
    } lb_rsp_t;

endpackage

// File: rtl/lb_decode.sv
module lb_decode #(
    parameter int unsigned            NUM_LOCKS = 32,
    parameter int unsigned            ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]      BASE_ADDR = 'h1000,
    parameter int unsigned            IDX_W     = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              err
);

    localparam logic [ADDR_W:0] SEG_BYTES = (ADDR_W+1)'(NUM_LOCKS) << 2;

    if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
        $error("lb_decode: segment base must be a multiple of 4");
    end

    logic [ADDR_W:0] offset;
    logic            below_base;
    logic            past_end;
    logic            misaligned;

    always_comb begin
        offset     = {1'b0, addr} - {1'b0, BASE_ADDR};
        below_base = offset[ADDR_W];
        past_end   = (offset >= SEG_BYTES);
        misaligned = (addr[1:0] != 2'b00);
        err        = below_base | past_end | misaligned;
        idx        = offset[IDX_W+1:2];
    end

endmodule

// File: rtl/lb_array.sv
module lb_array #(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned IDX_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_en,
    input  logic                 op_clr,
    input  logic [IDX_W-1:0]     idx,
    output logic                 cur_bit,
    output logic [NUM_LOCKS-1:0] locks_q
);

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                locks_q[g] <= 1'b0;
            end else if (op_en && (idx == IDX_W'(g))) begin
                locks_q[g] <= ~op_clr;
            end
        end
    end

    always_comb begin
        cur_bit = 1'b0;
        for (int i = 0; i < NUM_LOCKS; i++) begin
            if (idx == IDX_W'(i)) begin
                cur_bit = locks_q[i];
            end
        end
    end

endmodule

// File: rtl/lb_ctrl.sv
module lb_ctrl
    import lock_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              dec_err,
    input  logic              cur_bit,
    input  logic              rsp_ready,
    output logic              req_ready,
    output logic              op_en,
    output logic              op_clr,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rsp_err
);

    lb_state_e state_q, state_d;
    lb_rsp_t   rsp_q, rsp_d;
    logic      accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rsp_q   <= '0;
        end else begin
            state_q <= state_d;
            rsp_q   <= rsp_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        rsp_d     = rsp_q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        accept    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                accept    = req_valid;
                if (req_valid) begin
                    state_d    = ST_RESP;
                    rsp_d.err  = dec_err;
                    rsp_d.data = '0;
                    if (!dec_err && (lb_cmd_e'(req_write) == CMD_READ)) begin
                        rsp_d.data[0] = cur_bit;
                    end
                end
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                if (rsp_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        op_en    = accept & ~dec_err;
        op_clr   = (lb_cmd_e'(req_write) == CMD_WRITE);
        rsp_data = rsp_q.data;
        rsp_err  = rsp_q.err;
    end

endmodule

// File: rtl/lock_bank.sv
module lock_bank
    import lock_bank_pkg::*;
#(
    parameter int unsigned       NUM_LOCKS = 32,
    parameter int unsigned       ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_be,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err
);

    localparam int unsigned IDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1;

    logic [IDX_W-1:0]     dec_idx;
    logic                 dec_err;
    logic                 cur_bit;
    logic                 op_en;
    logic                 op_clr;
    logic [NUM_LOCKS-1:0] locks_q;
    logic                 unused_ok;

    assign unused_ok = ^{req_wdata, req_be};

    lb_decode #(
        .NUM_LOCKS (NUM_LOCKS),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .IDX_W     (IDX_W)
    ) u_decode (
        .addr (req_addr),
        .idx  (dec_idx),
        .err  (dec_err)
    );

    lb_array #(
        .NUM_LOCKS (NUM_LOCKS),
        .IDX_W     (IDX_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_en   (op_en),
        .op_clr  (op_clr),
        .idx     (dec_idx),
        .cur_bit (cur_bit),
        .locks_q (locks_q)
    );

    lb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .dec_err   (dec_err),
        .cur_bit   (cur_bit),
        .rsp_ready (rsp_ready),
        .req_ready (req_ready),
        .op_en     (op_en),
        .op_clr    (op_clr),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_rdata),
        .rsp_err   (rsp_err)
    );

endmodule

// File: rtl/lock_bank_chk.sv
module lock_bank_chk #(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned IDX_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_write,
    input logic                 rsp_valid,
    input logic                 rsp_ready,
    input logic [31:0]          rsp_rdata,
    input logic                 rsp_err,
    input logic [IDX_W-1:0]     dec_idx,
    input logic                 dec_err,
    input logic [NUM_LOCKS-1:0] locks_q
);

    logic acc;
    assign acc = req_valid && req_ready;

    p_read_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && !dec_err) |=> locks_q[$past(dec_idx)]);

    p_zero_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[31:1] == 31'd0));

    p_write_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && !dec_err) |=> !locks_q[$past(dec_idx)]);

    p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(locks_q));

    p_err_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && dec_err) |=> $stable(locks_q));

    p_err_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 32'd0));

    p_one_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_rsp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

endmodule

bind lock_bank lock_bank_chk #(
    .NUM_LOCKS (NUM_LOCKS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .dec_idx   (dec_idx),
    .dec_err   (dec_err),
    .locks_q   (locks_q)
);

// File: tb/test_lock_bank.sv
module test_lock_bank;

    localparam int          CLK_PERIOD = 10;
    localparam int          N_LOCKS    = 32;
    localparam logic [31:0] BASE       = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = 4'hF;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit backpressure = 1'b0;
    int bp_cnt = 0;

    logic        model [N_LOCKS];
    logic [32:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lock_bank #(
        .NUM_LOCKS (N_LOCKS),
        .ADDR_W    (32),
        .BASE_ADDR (BASE)
    ) i_lock_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual err=%0b data=%08h expected err=%0b data=%08h",
                     req, act[32], act[31:0], exp[32], exp[31:0]);
        end
    endtask

    // back-pressure pattern: ready one cycle in four when enabled
    always @(posedge clk) begin
        bp_cnt <= bp_cnt + 1;
        rsp_ready <= backpressure ? (bp_cnt % 4 == 3) : 1'b1;
    end

    // driver: computes the expected response from the requirements
    task automatic do_req(input logic [31:0] addr, input logic wr, input logic [31:0] wd, input string tag);
        logic        err;
        int          idx;
        logic [32:0] exp;
        while (!req_ready) @(negedge clk);
        err = (addr < BASE) || (addr >= BASE + 4 * N_LOCKS) || (addr[1:0] != 2'b00);
        idx = int'((addr - BASE) >> 2);
        if (err) exp = {1'b1, 32'd0};
        else if (wr) begin
            exp = {1'b0, 32'd0};
            model[idx] = 1'b0;
        end else begin
            exp = {1'b0, 31'd0, model[idx]};
            model[idx] = 1'b1;
        end
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        req_valid = 1'b1;
        req_addr  = addr;
        req_write = wr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready && rsp_valid, "R7 pending response blocks requests",
              {32'd0, req_ready}, {32'd0, 1'b0});
    endtask

    // monitor: pops the scoreboard as responses are accepted
    logic        was_stalled = 1'b0;
    logic [32:0] stalled_val = '0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (was_stalled) begin
                check(rsp_valid && ({rsp_err, rsp_rdata} == stalled_val), "R8 held response",
                      {rsp_err, rsp_rdata}, stalled_val);
            end
            was_stalled = rsp_valid && !rsp_ready;
            stalled_val = {rsp_err, rsp_rdata};
            if (rsp_valid && rsp_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 response without request", {rsp_err, rsp_rdata}, 33'd0);
                end else begin
                    logic [32:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({rsp_err, rsp_rdata} == e, t, {rsp_err, rsp_rdata}, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N_LOCKS; i++) model[i] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid, "R1 idle after reset",
              {31'd0, rsp_valid, req_ready}, {31'd0, 1'b0, 1'b1});
        do_req(BASE + 32'h0,  1'b0, 32'd0, "R1 lock 0 free after reset");
        do_req(BASE + 32'h7C, 1'b0, 32'd0, "R1 last lock free after reset");
        // R2 destructive read
        do_req(BASE + 32'hC, 1'b0, 32'd0, "R2 first read of free lock returns 0");
        do_req(BASE + 32'hC, 1'b0, 32'd0, "R2 second read returns 1");
        do_req(BASE + 32'hC, 1'b0, 32'd0, "R2 held lock stays 1");
        // R3 write clears regardless of data
        do_req(BASE + 32'hC, 1'b1, 32'd0, "R3 write response zero");
        do_req(BASE + 32'hC, 1'b0, 32'd0, "R3 read after clear returns 0");
        do_req(BASE + 32'hC, 1'b1, 32'hFFFF_FFFF, "R3 write of all ones clears");
        do_req(BASE + 32'hC, 1'b0, 32'd0, "R3 read after all-ones write returns 0");
        // R4 index decode, neighbours untouched
        do_req(BASE + 32'h10, 1'b0, 32'd0, "R4 lock 4 free");
        do_req(BASE + 32'h14, 1'b0, 32'd0, "R4 lock 5 independent of lock 4");
        do_req(BASE + 32'h10, 1'b1, 32'd0, "R4 release lock 4");
        do_req(BASE + 32'h14, 1'b0, 32'd0, "R4 lock 5 still held");
        // R5 out of range, including an alias of lock 0 and last lock
        do_req(BASE + 32'h80, 1'b1, 32'd0, "R5 first word past end errors");
        do_req(BASE - 32'h4,  1'b1, 32'd0, "R5 word below base errors");
        do_req(32'h0,         1'b0, 32'd0, "R5 address zero errors");
        do_req(BASE + 32'h0,  1'b0, 32'd0, "R5 lock 0 unchanged by errors");
        do_req(BASE + 32'h7C, 1'b0, 32'd0, "R5 last lock unchanged by errors");
        // R6 misaligned
        do_req(BASE + 32'h4, 1'b0, 32'd0, "R6 take lock 1");
        do_req(BASE + 32'h5, 1'b1, 32'd0, "R6 misaligned write errors");
        do_req(BASE + 32'h4, 1'b0, 32'd0, "R6 lock 1 still held");
        do_req(BASE + 32'hA, 1'b0, 32'd0, "R6 misaligned read errors");
        do_req(BASE + 32'h8, 1'b0, 32'd0, "R6 lock 2 still free");
        // R7 and R8 under back-pressure
        backpressure = 1'b1;
        do_req(BASE + 32'h18, 1'b0, 32'd0, "R7 stalled read returns 0");
        do_req(BASE + 32'h18, 1'b0, 32'd0, "R7 stalled read returns 1");
        do_req(BASE + 32'h18, 1'b1, 32'd0, "R7 stalled write");
        do_req(BASE + 32'h200, 1'b0, 32'd0, "R7 stalled error");
        do_req(BASE + 32'h18, 1'b0, 32'd0, "R7 stalled read after release");
        while (exp_q.size() != 0) @(negedge clk);
        backpressure = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule